// File: doc/BRIEF.md
# Masked Module Reset Controller

This block is a small register bank that keeps a set of peripheral modules in reset or lets them run. Control words are 32 bits wide. The upper half of each word is a per-bit write mask and the lower half carries the new reset values. This lets software change any single module's reset without a read-modify-write. Each module gets one active-low reset output. A status word at a fixed distance above each control word reports the reset state each module has actually reached.

Reset pulses must be long enough for modules that run from a slow reference clock. The block watches that clock through a synchroniser. It holds off any release until the reference clock has shown two rising edges since the reset was last asserted, so every pulse spans at least one full reference period. The status word follows the outputs through the same slow clock. It therefore shows the state that slow-clocked logic has seen. Synchronising the outputs into each module's own clock domain is left to the receiving logic.

Top module: `mod_reset_ctrl`

## Requirements
- R1: Control word w sits at byte address 4*w and covers modules 16*w to 16*w+15. Writing it with mask bit 16+n set and data bit n clear drives `modRstN` for that module low on the first clock edge after the write.
- R2: Writing mask bit 16+n set with data bit n set stores a release request for that module. If the minimum reset time has already elapsed, the output goes high on the second clock edge after the write.
- R3: A module whose mask bit is clear in a write keeps both its stored control bit and its output. An output only falls as the result of a masked assert write to its word.
- R4: The status word for control word w sits at byte address 0x180 + 4*w. Bit n reads 1 when the module is released and 0 when it is held in reset. It changes only after two synchronised rising edges of `refClk` have passed since the output changed. It reads as 0 immediately after a release.
- R5: After an assert, a release does not reach the output until two rising edges of `refClk` have been seen. A release written earlier is kept pending and takes effect as soon as that count is reached.
- R6: Every assert write restarts the two-edge minimum. An assert written while a release is pending cancels that release.
- R7: While `rstN` is low and after it is released, all `modRstN` outputs are low and all control and status words read zero.
- R8: A read returns data on the clock after `rdEn`. Control reads give the stored control bits (1 = release requested) in bits 15:0 and zero in bits 31:16.
- R9: Writes to status addresses, unmapped addresses or addresses with bits 1:0 non-zero change nothing. Reads from unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and control clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| refClk | input | 1 | Slow reference clock, sampled through a synchroniser |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 10 | Byte address |
| wrData | input | 32 | Write data: mask in bits 31:16, values in bits 15:0 |
| rdData | output | 32 | Registered read data |
| modRstN | output | 32 | Active-low reset per module |

## Verification
A lost or stale hold counter shows up as a release that reaches `modRstN` too early or never arrives. A too-early release is visible within one reference period of the assert. The bench probes inside that window and again after it. A corrupted control bit can be caught two ways: through a control read on the next cycle, or through the output diverging from the requested state, which it does within two clocks once the minimum has passed. A broken status pipeline shows as a status word that either leads the output before any reference edge or still lags after several reference periods.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  localparam int unsigned NUM_WORDS = 2;
  localparam int unsigned LANES     = 16;
  localparam int unsigned WORD_W    = 2 * LANES;
  localparam int unsigned NUM_MODS  = NUM_WORDS * LANES;
  localparam int unsigned ADDR_W    = 10;
  localparam int unsigned IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [ADDR_W-1:0] MON_OFS   = ADDR_W'('h180);
  localparam logic [ADDR_W-1:0] WORD_SPAN = ADDR_W'(NUM_WORDS * 4);

  typedef struct packed {
    logic [NUM_WORDS-1:0] wrSel;
    logic                 refEdge;
    logic                 rdEn;
    logic                 rdCtrl;
    logic                 rdMon;
    logic [IDX_W-1:0]     rdIdx;
  } strobe_t;
endpackage

// File: rtl/mrc_ctrl.sv
module mrc_ctrl
  import mrc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              refClk,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  logic [2:0] refSync;
  logic [ADDR_W-1:0] monOff;
  logic aligned, inCtrl, inMon;
  logic [IDX_W-1:0] ctrlIdx, monIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refSync <= '0;
    else       refSync <= {refSync[1:0], refClk};
  end

  always_comb begin
    monOff  = addr - MON_OFS;
    aligned = (addr[1:0] == 2'b00);
    inCtrl  = aligned && (addr < WORD_SPAN);
    inMon   = aligned && (addr >= MON_OFS) && (monOff < WORD_SPAN);
    ctrlIdx = addr[IDX_W+1:2];
    monIdx  = monOff[IDX_W+1:2];
  end

  always_comb begin
    stb.refEdge = refSync[1] & ~refSync[2];
    stb.rdEn    = rdEn;
    stb.rdCtrl  = inCtrl;
    stb.rdMon   = inMon;
    stb.rdIdx   = inMon ? monIdx : ctrlIdx;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_sel
    assign stb.wrSel[w] = wrEn && inCtrl && (ctrlIdx == IDX_W'(w));
  end
endmodule

// File: rtl/mrc_lane.sv
module mrc_lane #(
  parameter int unsigned MIN_REF_EDGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic refEdge,
  input  logic wrHit,
  input  logic wrVal,
  output logic ctrlBit,
  output logic relOut,
  output logic monBit
);
  localparam int unsigned CNT_W = $clog2(MIN_REF_EDGES + 1);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_REF_EDGES);

  logic [CNT_W-1:0] holdCnt;
  logic holdDone, assertWr, monStage;

  assign holdDone = (holdCnt >= CNT_MIN);
  assign assertWr = wrHit && !wrVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlBit <= 1'b0;
      relOut  <= 1'b0;
      holdCnt <= '0;
    end else begin
      if (wrHit) ctrlBit <= wrVal;
      if (assertWr)                relOut <= 1'b0;
      else if (ctrlBit && holdDone) relOut <= 1'b1;
      if (assertWr)                 holdCnt <= '0;
      else if (refEdge && !holdDone) holdCnt <= holdCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      monStage <= 1'b0;
      monBit   <= 1'b0;
    end else if (refEdge) begin
      monStage <= relOut;
      monBit   <= monStage;
    end
  end
endmodule

// File: rtl/mrc_bank.sv
module mrc_bank
  import mrc_pkg::*;
#(
  parameter int unsigned MIN_REF_EDGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [WORD_W-1:0]   wrData,
  output logic [WORD_W-1:0]   rdData,
  output logic [NUM_MODS-1:0] modRstN
);
  logic [LANES-1:0] ctrlWord [NUM_WORDS];
  logic [LANES-1:0] monWord  [NUM_WORDS];
  logic [WORD_W-1:0] rdNext;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      mrc_lane #(.MIN_REF_EDGES(MIN_REF_EDGES)) u_lane (
        .clk    (clk),
        .rstN   (rstN),
        .refEdge(stb.refEdge),
        .wrHit  (stb.wrSel[w] && wrData[LANES + l]),
        .wrVal  (wrData[l]),
        .ctrlBit(ctrlWord[w][l]),
        .relOut (modRstN[w*LANES + l]),
        .monBit (monWord[w][l])
      );
    end
  end

  always_comb begin
    rdNext = '0;
    if (stb.rdCtrl)     rdNext = {{LANES{1'b0}}, ctrlWord[stb.rdIdx]};
    else if (stb.rdMon) rdNext = {{LANES{1'b0}}, monWord[stb.rdIdx]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (stb.rdEn) rdData <= rdNext;
  end
endmodule

// File: rtl/mod_reset_ctrl.sv
module mod_reset_ctrl
  import mrc_pkg::*;
#(
  parameter int unsigned MIN_REF_EDGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                refClk,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wrData,
  output logic [WORD_W-1:0]   rdData,
  output logic [NUM_MODS-1:0] modRstN
);
  strobe_t stb;

  mrc_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .refClk(refClk),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .addr  (addr),
    .stb   (stb)
  );

  mrc_bank #(.MIN_REF_EDGES(MIN_REF_EDGES)) u_bank (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .rdData (rdData),
    .modRstN(modRstN)
  );
endmodule

// File: rtl/mrc_checker.sv
module mrc_checker
  import mrc_pkg::*;
#(
  parameter int unsigned MIN_REF_EDGES = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [WORD_W-1:0]   wrData,
  input logic [WORD_W-1:0]   rdData,
  input logic [NUM_MODS-1:0] modRstN,
  input logic                refEdge
);
  localparam int unsigned CW = $clog2(MIN_REF_EDGES + 2);
  logic [CW-1:0] edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   edgeCnt <= '0;
    else if (modRstN[0])         edgeCnt <= '0;
    else if (refEdge && edgeCnt < CW'(MIN_REF_EDGES)) edgeCnt <= edgeCnt + 1'b1;
  end

  // R1
  assert_now_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == '0 && wrData[LANES] && !wrData[0]) |=> !modRstN[0]);

  // R3
  only_masked_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modRstN[0]) |-> $past(wrEn && addr == '0 && wrData[LANES] && !wrData[0]));

  // R5
  min_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modRstN[0]) |-> (edgeCnt >= CW'(MIN_REF_EDGES)));

  // R7
  reset_hold_chk: assert property (@(posedge clk)
    !rstN |=> (modRstN == '0));

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[WORD_W-1:LANES] == '0);
endmodule

bind mod_reset_ctrl mrc_checker #(.MIN_REF_EDGES(MIN_REF_EDGES)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrData (wrData),
  .rdData (rdData),
  .modRstN(modRstN),
  .refEdge(stb.refEdge)
);

// File: tb/mod_reset_ctrl_test.sv
module mod_reset_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refClk = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] modRstN;
  logic [31:0] expRst;
  logic [31:0] rv;
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  mod_reset_ctrl uut (
    .clk(clk), .rstN(rstN), .refClk(refClk), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .modRstN(modRstN)
  );

  always #5 clk = ~clk;
  always #200 refClk = ~refClk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0; addr = '0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0; addr = '0; d = rdData;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R7 outputs in reset", modRstN, 32'h0);
    rstN = 1'b1;
    wait_clk(2);
    check("R7 outputs after reset", modRstN, 32'h0);
    rd(10'h000, rv); check("R7 ctrl0 zero", rv, 32'h0);
    rd(10'h004, rv); check("R7 ctrl1 zero", rv, 32'h0);
    rd(10'h180, rv); check("R7 status0 zero", rv, 32'h0);
    expRst = '0;
  endtask

  task automatic t_release_mix();
    wait_clk(160);
    wr(10'h000, 32'h000F_0005);
    wait_clk(1);
    expRst[3:0] = 4'b0101;
    check("R2 release lanes 0 and 2", modRstN, expRst);
    rd(10'h000, rv); check("R8 ctrl0 readback", rv, 32'h0000_0005);
    rd(10'h180, rv); check("R4 status lags release", rv, 32'h0);
    wait_clk(130);
    rd(10'h180, rv); check("R4 status after ref edges", rv, 32'h0000_0005);
  endtask

  task automatic t_mask_keep();
    wr(10'h000, 32'h0002_FFFF);
    wait_clk(1);
    expRst[1] = 1'b1;
    check("R3 only masked lane moves", modRstN, expRst);
    rd(10'h000, rv); check("R3 ctrl0 others kept", rv, 32'h0000_0007);
  endtask

  task automatic t_min_width();
    wr(10'h000, 32'h0001_0000);
    expRst[0] = 1'b0;
    check("R1 assert next edge", modRstN, expRst);
    wr(10'h000, 32'h0001_0001);
    wait_clk(2);
    check("R5 early release held", modRstN, expRst);
    rd(10'h000, rv); check("R5 pending release stored", rv, 32'h0000_0007);
    wait_clk(130);
    expRst[0] = 1'b1;
    check("R5 release after minimum", modRstN, expRst);
  endtask

  task automatic t_restart();
    wr(10'h000, 32'h0004_0000);
    expRst[2] = 1'b0;
    check("R1 assert lane 2", modRstN, expRst);
    wait_clk(85);
    wr(10'h000, 32'h0004_0000);
    wr(10'h000, 32'h0004_0004);
    wait_clk(30);
    check("R6 re-assert restarts window", modRstN, expRst);
    wait_clk(100);
    expRst[2] = 1'b1;
    check("R6 release after restarted window", modRstN, expRst);
    wr(10'h000, 32'h0004_0000);
    wr(10'h000, 32'h0004_0004);
    wr(10'h000, 32'h0004_0000);
    wait_clk(130);
    expRst[2] = 1'b0;
    check("R6 pending release cancelled", modRstN, expRst);
    rd(10'h000, rv); check("R6 ctrl0 after cancel", rv, 32'h0000_0003);
  endtask

  task automatic t_ignored();
    wr(10'h180, 32'hFFFF_FFFF);
    wr(10'h100, 32'hFFFF_FFFF);
    wr(10'h002, 32'hFFFF_FFFF);
    wait_clk(2);
    check("R9 stray writes ignored", modRstN, expRst);
    rd(10'h000, rv); check("R9 ctrl0 untouched", rv, 32'h0000_0003);
    rd(10'h100, rv); check("R9 unmapped read zero", rv, 32'h0);
  endtask

  task automatic t_word1();
    wr(10'h004, 32'h8000_8000);
    wait_clk(1);
    expRst[31] = 1'b1;
    check("R2 word1 lane 15 release", modRstN, expRst);
    rd(10'h004, rv); check("R8 ctrl1 readback", rv, 32'h0000_8000);
    wait_clk(130);
    rd(10'h184, rv); check("R4 status1", rv, 32'h0000_8000);
  endtask

  initial begin
    wait_clk(3);
    t_reset();
    t_release_mix();
    t_mask_keep();
    t_min_width();
    t_restart();
    t_ignored();
    t_word1();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule